// File: doc/BRIEF.md
# Chainable Presettable Binary Up-Counter

This block counts upward in binary. It is built from identical 4-bit stages. Each stage has a synchronous clear, a synchronous parallel preset, and two count enables. The first enable is shared by every stage. The second is a carry input that also qualifies the stage's end-of-range flag. The top module chains a parameterised number of stages. It feeds each stage's end-of-range flag into the carry input of the stage above, so the chain behaves as one counter whose width is four times the stage count.

All state changes happen on the rising clock edge; no input reaches the count asynchronously. At an edge, clear takes precedence over preset, and preset takes precedence over counting. The carry-out is combinational, so the stage above sees it in the same cycle. A shorter count cycle is made by feeding a decode of the count back into the clear input. Because the clear is synchronous, the decoded value stays on the outputs for one full cycle before the counter returns to zero. These pins are plain control and status signals: there is no streaming data path, so no valid/ready handshake applies.

Top module: `casc_counter`

## Requirements
- R1: When `rst_n` is 0 at a rising edge, `q` becomes 0 after that edge, whatever `load_n`, `din`, `cnt_en` and `carry_en` are.
- R2: When `rst_n` is 1 and `load_n` is 0 at a rising edge, `q` takes the value of `din`, whatever either enable is.
- R3: When `rst_n` and `load_n` are both 1 and `cnt_en` and `carry_en` are both 1, `q` increases by exactly one at the edge.
- R4: When `rst_n` and `load_n` are both 1 and either enable is 0, `q` keeps its value across the edge.
- R5: Counting from the all-ones value wraps `q` to 0 on the next enabled increment.
- R6: `tc_out` is 1 exactly when `carry_en` is 1 and `q` is all ones. It follows these inputs in the same cycle, and `cnt_en` has no effect on it.
- R7: A stage's carry input is 1 only when every lower nibble is 15 and `carry_en` is 1. A carry therefore moves across a 4-bit boundary in the same edge as the low nibble wraps, and the whole `q` counts as one binary number.
- R8: When `rst_n` is driven from a decode of `q` equal to a value K, the count goes 0,1,…,K,0. Each value, K included, is present for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge is active |
| rst_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous preset from `din`, active low |
| din | input | 4*STAGES | Preset value |
| cnt_en | input | 1 | Count enable shared by all stages; does not affect `tc_out` |
| carry_en | input | 1 | Carry-in of the lowest stage; also qualifies `tc_out` |
| q | output | 4*STAGES | Count value |
| tc_out | output | 1 | End-of-range flag of the top stage (carry-out) |

## Verification
The clocked properties assume that every input is a known 0 or 1 at each rising edge. They also assume that `rst_n` is low at the first edge, so that each `$past` of the count refers to a defined value. The bench holds the clear low from time zero and changes inputs only on falling edges. It samples the count a quarter period after each rising edge and checks the flag one nanosecond after the inputs change. Every combination of clear, preset and the two enables is applied, together with wrap-around, a carry across a nibble boundary and a decoded short cycle.

// File: rtl/casc_cnt_pkg.sv
package casc_cnt_pkg;
  localparam int NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;

  typedef enum logic [1:0] {
    ACT_CLEAR = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_STEP  = 2'd2,
    ACT_HOLD  = 2'd3
  } act_e;

  // Fixed priority: clear, then preset, then count.
  function automatic act_e pick_act(input logic rst_n, input logic load_n,
                                    input logic en_p, input logic en_t);
    if (!rst_n)           return ACT_CLEAR;
    else if (!load_n)     return ACT_LOAD;
    else if (en_p && en_t) return ACT_STEP;
    else                  return ACT_HOLD;
  endfunction
endpackage

// File: rtl/casc_cnt_next_sel.sv
module casc_cnt_next_sel
  import casc_cnt_pkg::*;
(
  input  nib_t cur,
  input  nib_t din,
  input  logic rst_n,
  input  logic load_n,
  input  logic en_p,
  input  logic en_t,
  output nib_t nxt
);
  act_e act;

  always_comb begin
    act = pick_act(rst_n, load_n, en_p, en_t);
    unique case (act)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = din;
      ACT_STEP:  nxt = cur + nib_t'(1);
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/casc_cnt_stage.sv
module casc_cnt_stage
  import casc_cnt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_n,
  input  logic en_p,
  input  logic en_t,
  input  nib_t din,
  output nib_t q,
  output logic tc
);
  nib_t nxt;

  casc_cnt_next_sel u_sel (
    .cur    (q),
    .din    (din),
    .rst_n  (rst_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .nxt    (nxt)
  );

  always_ff @(posedge clk) q <= nxt;

  // Carry-out qualified only by the trickle enable, never by en_p.
  assign tc = en_t & (&q);

  AST_CLEAR_WINS: assert property (@(posedge clk)
    !rst_n |=> (q == '0)); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !load_n) |=> (q == $past(din))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && load_n && !(en_p && en_t)) |=> $stable(q)); // R4
  AST_NIB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && load_n && en_p && en_t && (q == '1)) |=> (q == '0)); // R5
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import casc_cnt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_n,
  input  logic [STAGES*NIB_W-1:0]   din,
  input  logic                      cnt_en,
  input  logic                      carry_en,
  output logic [STAGES*NIB_W-1:0]   q,
  output logic                      tc_out
);
  localparam int W = STAGES * NIB_W;

  logic [STAGES:0] trickle;
  assign trickle[0] = carry_en;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    casc_cnt_stage u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_n (load_n),
      .en_p   (cnt_en),
      .en_t   (trickle[i]),
      .din    (din[i*NIB_W +: NIB_W]),
      .q      (q[i*NIB_W +: NIB_W]),
      .tc     (trickle[i+1])
    );
  end

  assign tc_out = trickle[STAGES];

  AST_FLAG_MEANS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> (carry_en && (q == '1))); // R6
  AST_FULL_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_en && (q == '1)) |-> tc_out); // R6
  AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && load_n && cnt_en && carry_en) |=> (q == W'($past(q) + 1'b1))); // R7
  AST_WIDE_STEP_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && load_n && cnt_en && carry_en) |=> (q != $past(q))); // R3
endmodule

// File: tb/casc_counter_test.sv
module casc_counter_test;
  localparam int STAGES = 2;
  localparam int W = STAGES * 4;

  typedef struct {
    logic [W-1:0] q;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_n = 1'b1;
  logic [W-1:0] din = '0;
  logic cnt_en = 1'b0;
  logic carry_en = 1'b0;
  logic [W-1:0] q;
  logic tc_out;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] model = '0;
  exp_t sb[$];
  bit done = 1'b0;

  casc_counter #(.STAGES(STAGES)) uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .cnt_en(cnt_en), .carry_en(carry_en), .q(q), .tc_out(tc_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply inputs at the falling edge, check the flag, queue the next count.
  task automatic step(input logic r, input logic l, input logic [W-1:0] d,
                      input logic ep, input logic et, input string tag);
    @(negedge clk);
    rst_n = r; load_n = l; din = d; cnt_en = ep; carry_en = et;
    #1;
    chk("R6", W'(tc_out), W'(et && (model == '1)));
    if (!r)            model = '0;
    else if (!l)       model = d;
    else if (ep && et) model = model + 1'b1;
    sb.push_back('{q: model, tag: tag});
  endtask

  // Monitor: compare a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, q, e.q);
      end
    end
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: clear with other inputs busy
    step(0, 0, 8'hA5, 1, 1, "R1");
    step(0, 1, 8'h00, 1, 1, "R1");
    // R2: preset regardless of enables
    step(1, 0, 8'h0D, 0, 0, "R2");
    step(1, 0, 8'h0D, 1, 1, "R2");
    // R3 and R7: count across the nibble boundary
    step(1, 1, 8'h00, 1, 1, "R3");
    step(1, 1, 8'h00, 1, 1, "R7");
    step(1, 1, 8'h00, 1, 1, "R7");
    // R4: hold with either enable low
    step(1, 1, 8'h00, 0, 1, "R4");
    step(1, 1, 8'h00, 1, 0, "R4");
    // R6 and R5: flag at all ones, then wrap
    step(1, 0, 8'hFF, 0, 0, "R2");
    step(1, 1, 8'h00, 0, 1, "R6");
    step(1, 1, 8'h00, 0, 0, "R6");
    step(1, 1, 8'h00, 1, 1, "R5");
    step(1, 0, 8'hFE, 0, 0, "R2");
    step(1, 1, 8'h00, 1, 1, "R3");
    step(1, 1, 8'h00, 1, 1, "R5");
    // Every priority combination
    for (int c = 0; c < 16; c++) begin
      string tg;
      tg = !c[3] ? "R1" : !c[2] ? "R2" : (c[1] && c[0]) ? "R3" : "R4";
      step(1, 0, 8'h3F, 0, 0, "R2");
      step(c[3], c[2], 8'hC6, c[1], c[0], tg);
    end
    // R8: short cycle from a decode of the count equal to 5
    step(1, 0, 8'h00, 0, 0, "R2");
    for (int k = 0; k < 14; k++) begin
      step((model != 8'd5), 1, 8'h00, 1, 1, "R8");
    end
    step(1, 1, 8'h00, 0, 0, "R4");
    while (sb.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule